// File: doc/BRIEF.md
# Framed Serial Byte Slave with Status Bit

This block is the device-side end of a four-wire serial link that moves one byte per transaction. Each transaction is a fixed frame of twelve serial clocks. The master first sends three header bits: a start marker, a direction bit and a register-select bit. Eight data bits follow, most significant first. The slave then returns one status bit. Select is active high for the whole frame and drops between frames. A faster system clock oversamples the serial clock, select and data through synchronisers. The slave samples on rising serial-clock edges and changes its output on falling edges.

On the device side there are two registers. The data register has a read byte, which the device loads, and a "fresh" flag. A successful read clears the flag, and a status bit of 1 tells the master that the byte it got was stale. Writes to the data register appear as a byte with a one-cycle strobe. If the device side is not ready, the write is refused and the status bit reports the refusal. The status register reads back a device-supplied byte and captures a byte written by the master.

The frame controller has seven states:
- IDLE: select low.
- START: expects the start bit.
- DIR: captures the direction.
- ADDR: captures the register select and snapshots the outgoing byte.
- DATA: eight bits.
- STAT: the status bit and the commit.
- HOLD: a finished or rejected frame waits for select to fall.

The transitions are:
- IDLE to START when select is seen high.
- START to DIR on a rising edge with a start bit of 1, or START to HOLD with a start bit of 0.
- DIR to ADDR, and ADDR to DATA, on a rising edge.
- DATA to STAT on the eighth data rising edge.
- STAT to HOLD on the twelfth rising edge.
- Any state to IDLE when select is seen low.

Top module: `fspi_slave`

## Requirements
- R1: After reset, `sdo_o`, `wr_stb_o` and `rd_fresh_o` are 0 and `host_stat_o` is 0x00.
- R2: A frame whose first sampled bit is 0 is ignored until select falls. No strobe fires, no flag or register changes, and `sdo_o` stays 0 for all twelve clocks.
- R3: A frame with header bits 1,1,0 (start, direction 1 = read, register select 0 = data) returns the held read byte on `sdo_o`. The bits come MSB first and are valid at rising edges 4 to 11, and the status bit is valid at rising edge 12.
- R4: A pulse on `rd_load_i` stores `rd_data_i` and sets `rd_fresh_o`. A data-register read returns status 0 when the byte was fresh and then clears `rd_fresh_o`. A repeated read returns the same byte with status 1.
- R5: Header 1,0,0 (direction 0 = write, data register) with `wr_ready_i` high at the last data bit returns status 0. It then pulses `wr_stb_o` for one cycle with `wr_data_o` equal to the received byte after rising edge 12.
- R6: The same write with `wr_ready_i` low returns status 1. It raises no strobe and leaves `wr_data_o` unchanged.
- R7: Header 1,0,1 (write, status register) loads the received byte into `host_stat_o` at the end of the frame. It returns status 0 and raises no write strobe.
- R8: Header 1,1,1 (read, status register) returns `dev_stat_i` as sampled at the register-select bit, with status 0. It leaves `rd_fresh_o` unchanged.
- R9: If select falls before rising edge 12, the frame is abandoned. No strobe fires, `rd_fresh_o` does not change and `host_stat_o` does not change.
- R10: `sdo_o` is 0 while select is low, during the three header bits, and during the data bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| sel_i | input | 1 | Active-high frame select |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data and status to the master |
| rd_load_i | input | 1 | Device strobe that loads a new read byte |
| rd_data_i | input | DW | Read byte to load |
| rd_fresh_o | output | 1 | Held read byte not yet consumed |
| wr_ready_i | input | 1 | Device side can accept a written byte |
| wr_stb_o | output | 1 | One-cycle strobe for an accepted write |
| wr_data_o | output | DW | Last accepted written byte |
| dev_stat_i | input | DW | Byte returned by status-register reads |
| host_stat_o | output | DW | Byte last written to the status register |

## Verification
A controller that skips or repeats a header state shifts the data byte by one position. That shows as a wrong byte on `sdo_o` within the same frame. A wrong status decision, such as using a stale fresh snapshot or sampling readiness at the wrong time, shows as a wrong status bit at rising edge 12. It also shows a few system cycles later as a missing or extra strobe or fresh-flag change. A commit that ignores the select level shows as a strobe or register change after an aborted frame. That is visible before the next frame starts.

// File: rtl/fspi_pkg.sv
`timescale 1ns/1ps
package fspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DIR   = 3'd2,
        ST_ADDR  = 3'd3,
        ST_DATA  = 3'd4,
        ST_STAT  = 3'd5,
        ST_HOLD  = 3'd6
    } fr_state_t;

    localparam logic DIR_RD   = 1'b1;
    localparam logic REG_DATA = 1'b0;
    localparam logic REG_STAT = 1'b1;
    localparam logic START_MARK = 1'b1;

endpackage

// File: rtl/fspi_sync.sv
`timescale 1ns/1ps
module fspi_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/fspi_rdbuf.sv
`timescale 1ns/1ps
module fspi_rdbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    input  logic          snap_i,
    input  logic          consume_i,
    output logic [DW-1:0] byte_o,
    output logic          fresh_o
);

    // set when a new byte arrived after the frame took its snapshot
    logic reloaded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o   <= '0;
            fresh_o  <= 1'b0;
            reloaded <= 1'b0;
        end else begin
            if (load_i) begin
                byte_o  <= data_i;
                fresh_o <= 1'b1;
            end else if (consume_i && !reloaded) begin
                fresh_o <= 1'b0;
            end
            if (snap_i)      reloaded <= load_i;
            else if (load_i) reloaded <= 1'b1;
        end
    end

endmodule

// File: rtl/fspi_frame.sv
`timescale 1ns/1ps
module fspi_frame
    import fspi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sel_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rbuf_byte_i,
    input  logic          rbuf_fresh_i,
    input  logic [DW-1:0] dev_stat_i,
    input  logic          wr_ready_i,
    output logic          snap_o,
    output logic          consume_o,
    output logic          wr_stb_o,
    output logic [DW-1:0] wr_data_o,
    output logic [DW-1:0] host_stat_o,
    output logic          sdo_o,
    output fr_state_t     state_o,
    output logic          rise_o
);

    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    fr_state_t     state, nxt;
    logic          sclk_d;
    logic          rise, fall, last_bit;
    logic [CW-1:0] bit_cnt;
    logic          dir_q, reg_q, fresh_q, stat_q;
    logic [DW-1:0] rx_sh, tx_sh;
    logic          stat_now;

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign last_bit = (bit_cnt == CW'(DW-1));
    assign state_o  = state;
    assign rise_o   = rise;

    // status bit decided at the last data bit
    always_comb begin
        if (dir_q == DIR_RD) stat_now = (reg_q == REG_DATA) ? ~fresh_q : 1'b0;
        else                 stat_now = (reg_q == REG_DATA) ? ~wr_ready_i : 1'b0;
    end

    always_comb begin
        nxt = state;
        if (!sel_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_START;
                ST_START: if (rise) nxt = (sdi_s == START_MARK) ? ST_DIR : ST_HOLD;
                ST_DIR:   if (rise) nxt = ST_ADDR;
                ST_ADDR:  if (rise) nxt = ST_DATA;
                ST_DATA:  if (rise && last_bit) nxt = ST_STAT;
                ST_STAT:  if (rise) nxt = ST_HOLD;
                ST_HOLD:  nxt = ST_HOLD;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sclk_d <= 1'b0;
        end else begin
            state  <= nxt;
            sclk_d <= sclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_o      <= 1'b0;
            consume_o   <= 1'b0;
            wr_stb_o    <= 1'b0;
            wr_data_o   <= '0;
            host_stat_o <= '0;
            sdo_o       <= 1'b0;
            bit_cnt     <= '0;
            dir_q       <= 1'b0;
            reg_q       <= 1'b0;
            fresh_q     <= 1'b0;
            stat_q      <= 1'b0;
            rx_sh       <= '0;
            tx_sh       <= '0;
        end else begin
            snap_o    <= 1'b0;
            consume_o <= 1'b0;
            wr_stb_o  <= 1'b0;
            if (!sel_s) begin
                sdo_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_DIR: begin
                        if (rise) dir_q <= sdi_s;
                    end
                    ST_ADDR: begin
                        if (rise) begin
                            reg_q   <= sdi_s;
                            bit_cnt <= '0;
                            snap_o  <= 1'b1;
                            fresh_q <= rbuf_fresh_i;
                            if (dir_q == DIR_RD)
                                tx_sh <= (sdi_s == REG_STAT) ? dev_stat_i : rbuf_byte_i;
                            else
                                tx_sh <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (fall) begin
                            sdo_o <= tx_sh[DW-1];
                            tx_sh <= tx_sh << 1;
                        end
                        if (rise) begin
                            rx_sh   <= {rx_sh[DW-2:0], sdi_s};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) stat_q <= stat_now;
                        end
                    end
                    ST_STAT: begin
                        if (fall) sdo_o <= stat_q;
                        if (rise && !stat_q) begin
                            if (dir_q == DIR_RD) begin
                                if (reg_q == REG_DATA) consume_o <= 1'b1;
                            end else if (reg_q == REG_DATA) begin
                                wr_stb_o  <= 1'b1;
                                wr_data_o <= rx_sh;
                            end else begin
                                host_stat_o <= rx_sh;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (fall) sdo_o <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fspi_slave.sv
`timescale 1ns/1ps
module fspi_slave
    import fspi_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_i,
    input  logic          sel_i,
    input  logic          sdi_i,
    output logic          sdo_o,
    input  logic          rd_load_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          rd_fresh_o,
    input  logic          wr_ready_i,
    output logic          wr_stb_o,
    output logic [DW-1:0] wr_data_o,
    input  logic [DW-1:0] dev_stat_i,
    output logic [DW-1:0] host_stat_o
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_q;
    logic             sclk_s, sel_s, sdi_s;
    logic             snap, consume, sclk_rise;
    logic [DW-1:0]    rbuf_byte;
    fr_state_t        fr_state;

    fspi_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sclk_i, sel_i, sdi_i}),
        .q_o  (sync_q)
    );

    assign {sclk_s, sel_s, sdi_s} = sync_q;

    fspi_rdbuf #(.DW(DW)) u_rdbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (rd_load_i),
        .data_i   (rd_data_i),
        .snap_i   (snap),
        .consume_i(consume),
        .byte_o   (rbuf_byte),
        .fresh_o  (rd_fresh_o)
    );

    fspi_frame #(.DW(DW)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .sel_s       (sel_s),
        .sdi_s       (sdi_s),
        .rbuf_byte_i (rbuf_byte),
        .rbuf_fresh_i(rd_fresh_o),
        .dev_stat_i  (dev_stat_i),
        .wr_ready_i  (wr_ready_i),
        .snap_o      (snap),
        .consume_o   (consume),
        .wr_stb_o    (wr_stb_o),
        .wr_data_o   (wr_data_o),
        .host_stat_o (host_stat_o),
        .sdo_o       (sdo_o),
        .state_o     (fr_state),
        .rise_o      (sclk_rise)
    );

endmodule

// File: rtl/fspi_chk.sv
`timescale 1ns/1ps
module fspi_chk
    import fspi_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input fr_state_t     state,
    input logic          sel_s,
    input logic          sdo,
    input logic          wr_stb,
    input logic          consume,
    input logic          rd_load,
    input logic          rd_fresh,
    input logic [DW-1:0] host_stat
);

    // R10: output quiet while idle or in the header
    p_sdo_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_IDLE, ST_START, ST_DIR, ST_ADDR}) |-> !sdo);

    // R5: a write strobe only follows the status bit
    p_stb_after_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state == ST_HOLD && $past(state) == ST_STAT));

    // R4: a consume only follows the status bit
    p_consume_after_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (state == ST_HOLD && $past(state) == ST_STAT));

    // R6: one frame never both reads and writes
    p_one_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && consume));

    // R4: fresh flag only rises from a load
    p_fresh_from_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_fresh) |-> $past(rd_load));

    // R7: host status byte only changes at a frame commit
    p_host_stat_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_stat) |-> $past(state) == ST_STAT);

    // R9: select low blocks every commit
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> (!wr_stb && !consume));

endmodule

bind fspi_slave fspi_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fr_state),
    .sel_s    (sel_s),
    .sdo      (sdo_o),
    .wr_stb   (wr_stb_o),
    .consume  (consume),
    .rd_load  (rd_load_i),
    .rd_fresh (rd_fresh_o),
    .host_stat(host_stat_o)
);

// File: tb/sim_fspi_slave.sv
`timescale 1ns/1ps
module sim_fspi_slave;

    localparam int DW = 8;
    localparam realtime HP = 160ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk_i = 1'b0, sel_i = 1'b0, sdi_i = 1'b0;
    logic          sdo_o;
    logic          rd_load_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          rd_fresh_o;
    logic          wr_ready_i = 1'b0;
    logic          wr_stb_o;
    logic [DW-1:0] wr_data_o;
    logic [DW-1:0] dev_stat_i = '0;
    logic [DW-1:0] host_stat_o;

    int n_tests = 0, n_fail = 0;
    int stb_cnt = 0;
    logic [DW-1:0] last_w = '0;

    always #10 clk = ~clk;

    fspi_slave #(.DW(DW)) u0 (.*);

    always @(negedge clk) if (wr_stb_o) begin
        stb_cnt++;
        last_w = wr_data_o;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    // one frame of nclk serial clocks; captures what sdo showed at each rising edge
    task automatic xfer(input logic s, input logic dir, input logic rsel, input logic [7:0] wb,
                        input int nclk, output logic [7:0] rb, output logic st,
                        output logic [2:0] hdr);
        logic [11:0] tx, seen;
        tx = {s, dir, rsel, wb, 1'b0};
        seen = '0;
        sel_i = 1'b1;
        sdi_i = tx[11];
        #(HP);
        for (int i = 0; i < nclk; i++) begin
            sdi_i = tx[11-i];
            #(HP);
            seen[11-i] = sdo_o;
            sclk_i = 1'b1;
            #(HP);
            sclk_i = 1'b0;
        end
        #(HP);
        sel_i = 1'b0;
        sdi_i = 1'b0;
        #(4*HP);
        rb  = seen[8:1];
        st  = seen[0];
        hdr = seen[11:9];
    endtask

    task automatic load(input logic [7:0] b);
        @(negedge clk);
        rd_load_i = 1'b1;
        rd_data_i = b;
        @(negedge clk);
        rd_load_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "sdo", sdo_o, 0);
        chk("R1", "wr_stb", stb_cnt, 0);
        chk("R1", "fresh", rd_fresh_o, 0);
        chk("R1", "host_stat", host_stat_o, 0);
    endtask

    task automatic t_read_fresh();
        logic [7:0] rb; logic st; logic [2:0] h;
        load(8'hA5);
        chk("R4", "fresh after load", rd_fresh_o, 1);
        xfer(1, 1, 0, 8'h00, 12, rb, st, h);
        chk("R3", "read byte", rb, 8'hA5);
        chk("R4", "status fresh", st, 0);
        chk("R10", "header sdo", h, 0);
        chk("R4", "fresh cleared", rd_fresh_o, 0);
        xfer(1, 1, 0, 8'h00, 12, rb, st, h);
        chk("R4", "reread byte", rb, 8'hA5);
        chk("R4", "status stale", st, 1);
    endtask

    task automatic t_write_ok();
        logic [7:0] rb; logic st; logic [2:0] h;
        int c0 = stb_cnt;
        wr_ready_i = 1'b1;
        xfer(1, 0, 0, 8'h3C, 12, rb, st, h);
        chk("R5", "status accept", st, 0);
        chk("R5", "strobe count", stb_cnt - c0, 1);
        chk("R5", "write data", last_w, 8'h3C);
        chk("R10", "sdo in write data", rb, 0);
        chk("R10", "sdo after frame", sdo_o, 0);
    endtask

    task automatic t_write_full();
        logic [7:0] rb; logic st; logic [2:0] h;
        int c0 = stb_cnt;
        wr_ready_i = 1'b0;
        xfer(1, 0, 0, 8'hC3, 12, rb, st, h);
        chk("R6", "status refuse", st, 1);
        chk("R6", "no strobe", stb_cnt - c0, 0);
        chk("R6", "data kept", wr_data_o, 8'h3C);
    endtask

    task automatic t_stat_write();
        logic [7:0] rb; logic st; logic [2:0] h;
        int c0 = stb_cnt;
        xfer(1, 0, 1, 8'h5A, 12, rb, st, h);
        chk("R7", "host_stat", host_stat_o, 8'h5A);
        chk("R7", "status", st, 0);
        chk("R7", "no strobe", stb_cnt - c0, 0);
    endtask

    task automatic t_stat_read();
        logic [7:0] rb; logic st; logic [2:0] h;
        load(8'h11);
        dev_stat_i = 8'h96;
        xfer(1, 1, 1, 8'h00, 12, rb, st, h);
        chk("R8", "status reg byte", rb, 8'h96);
        chk("R8", "status", st, 0);
        chk("R8", "fresh kept", rd_fresh_o, 1);
    endtask

    task automatic t_abort();
        logic [7:0] rb; logic st; logic [2:0] h;
        int c0 = stb_cnt;
        xfer(1, 1, 0, 8'h00, 10, rb, st, h);
        chk("R9", "fresh after aborted read", rd_fresh_o, 1);
        wr_ready_i = 1'b1;
        xfer(1, 0, 0, 8'hE7, 11, rb, st, h);
        chk("R9", "no strobe on abort", stb_cnt - c0, 0);
        xfer(1, 0, 1, 8'h42, 11, rb, st, h);
        chk("R9", "host_stat kept", host_stat_o, 8'h5A);
    endtask

    task automatic t_start0();
        logic [7:0] rb; logic st; logic [2:0] h;
        int c0 = stb_cnt;
        wr_ready_i = 1'b1;
        xfer(0, 0, 0, 8'hFF, 12, rb, st, h);
        chk("R2", "no strobe", stb_cnt - c0, 0);
        chk("R2", "sdo quiet", {h, rb, st}, 0);
        xfer(0, 0, 1, 8'h77, 12, rb, st, h);
        chk("R2", "host_stat kept", host_stat_o, 8'h5A);
        xfer(0, 1, 0, 8'h00, 12, rb, st, h);
        chk("R2", "fresh kept", rd_fresh_o, 1);
        xfer(1, 1, 0, 8'h00, 12, rb, st, h);
        chk("R3", "read after rejected frames", rb, 8'h11);
        chk("R4", "status fresh", st, 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_read_fresh();
        t_write_ok();
        t_write_full();
        t_stat_write();
        t_stat_read();
        t_abort();
        t_start0();
        summary();
        $finish;
    end

endmodule